// File: doc/BRIEF.md
# Hierarchical Reset and Strap Controller

This block turns a set of reset requests into a three-tier tree of reset outputs for a small two-port switch chip. At the top tier, the active-low power-on input and the external reset pin drive the chip-wide reset. The middle tier is the multi-module reset. Two register-driven requests feed it: a digital reset and a soft reset. The bottom tier has three per-module resets, one each for the two port PHYs and one for the virtual PHY.

A reset at any tier also resets every tier below it. Outputs go low at once, without waiting for a clock edge. They return high only through a two-flop synchronizer on the system clock.

The register-driven requests are one-cycle pulses, and the block stretches each one itself. The block also captures the configuration straps, but only when the chip-wide reset releases. It then emits a one-cycle start pulse for the non-volatile configuration loader. That pulse follows a chip-wide reset or a digital reset, and never a soft reset alone.

Top module: `rstgen_hier`

## Requirements
- R1: While `por_n` or `ext_rst_n` is low, every reset output and `strap_q` are 0. This takes effect without waiting for a clock edge. Once both inputs are high, `chip_rst_n` goes high after the second rising clock edge.
- R2: When `chip_rst_n` is low, `multi_rst_n` is low. When `multi_rst_n` is low, every bit of `mod_rst_n` is low. Each tier releases two edges after the tier above it.
- R3: Take the edge at which `dig_req` or `soft_req` is sampled high as edge k. `multi_rst_n` is low right after edge k and goes high after edge k+18: a 16-cycle hold plus two synchronizer stages. `mod_rst_n` goes high after edge k+20.
- R4: Bit i of `mod_req` resets only bit i of `mod_rst_n`. Bit 0 is port 1 PHY, bit 1 is port 2 PHY and bit 2 is the virtual PHY. The bit is low after edge k and high after edge k+18. The other bits and `multi_rst_n` stay high.
- R5: A new request that arrives while a stretched reset is still held restarts the hold. Release then comes 18 edges after the latest request.
- R6: On the third edge after chip-level release, `strap_q` takes the value of `strap_in` and `strap_stb` is high for exactly that one cycle. `strap_q` holds its value at all other times, including through digital and soft resets.
- R7: `loader_start` is a one-cycle pulse on the edge after `multi_rst_n` rises, when that release follows a chip-level reset or a digital reset. It comes after edge 5 after chip-level release, or after edge k+19 for a digital request.
- R8: A soft reset on its own produces no `loader_start` pulse and no `strap_stb` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| dig_req | input | 1 | Digital reset request, one-cycle pulse |
| soft_req | input | 1 | Soft reset request, one-cycle pulse |
| mod_req | input | NUM_MOD | Per-module reset requests (0: port 1 PHY, 1: port 2 PHY, 2: virtual PHY) |
| strap_in | input | STRAP_W | Configuration strap pin values |
| chip_rst_n | output | 1 | Chip-wide reset, active low |
| multi_rst_n | output | 1 | Multi-module reset, active low |
| mod_rst_n | output | NUM_MOD | Per-module resets, active low |
| strap_q | output | STRAP_W | Captured strap values |
| strap_stb | output | 1 | One-cycle strobe marking a strap capture |
| loader_start | output | 1 | One-cycle start pulse for the configuration loader |

## Verification
Every delay is counted from one reference edge:

| Stimulus | Result | Due after edge |
|---|---|---|
| Chip-level release | `chip_rst_n` high | 2 |
| Chip-level release | `strap_stb` | 3 |
| Chip-level release | `multi_rst_n` high | 4 |
| Chip-level release | `loader_start` | 5 |
| Chip-level release | `mod_rst_n` high | 6 |
| Request sampled at edge 0 | stretched output high | 18 |
| Digital request at edge 0 | `loader_start` | 19 |
| Digital or soft request at edge 0 | `mod_rst_n` high | 20 |

The bench drives inputs and samples outputs on falling edges. It logs, per output, the first sample index at which the output is high and the index and count of each pulse. It compares those numbers to the values above.

Checks of asynchronous assertion sample 1 ns after the reset input falls, before any clock edge.

// File: rtl/rstgen_pkg.sv
// Package: shared defaults and module index names for the reset controller.
// Assumes: module index order is fixed and decoded by the per-module outputs.
package rstgen_pkg;
    localparam int HOLD_DEF   = 16;
    localparam int NMOD_DEF   = 3;
    localparam int STRAPW_DEF = 8;
    localparam int SYNC_DEF   = 2;

    typedef enum int {
        MOD_PORT1 = 0,
        MOD_PORT2 = 1,
        MOD_VPHY  = 2
    } mod_idx_e;
endpackage

// File: rtl/rst_sync.sv
// Reset synchronizer: the output clears at once when arst_n drops.
// It returns high after STAGES rising edges with arst_n high.
// Assumes: STAGES >= 2.
module rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [STAGES-1:0] sh;

    // Shift ones in after release; clear all stages asynchronously.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= {sh[STAGES-2:0], 1'b1};
    end

    assign rst_n_o = sh[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
// Request stretcher: a one-cycle req loads HOLD cycles.
// 'active' stays high until the count reaches zero.
// A req while active reloads the count.
// Assumes: rst_n is a synchronous active-low clear; clk runs during reset.
module rst_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active
);
    localparam int CW = $clog2(HOLD + 1);
    logic [CW-1:0] cnt;

    // Load on request, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (req)        cnt <= CW'(HOLD);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/strap_capture.sv
// Strap latch: samples strap_in once, on the first edge that sees
// chip_rst_n high after it was low, and pulses strb for that cycle.
// Assumes: arst_n is the raw chip-level reset (low clears the held value).
module strap_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         chip_rst_n,
    input  logic [W-1:0] strap_in,
    output logic [W-1:0] strap_q,
    output logic         strb
);
    logic chip_prev;

    // Track previous chip reset level to find its release.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chip_prev <= 1'b0;
        else         chip_prev <= chip_rst_n;
    end

    // Capture straps and strobe on the release edge only.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            strap_q <= '0;
            strb    <= 1'b0;
        end else begin
            strb <= chip_rst_n & ~chip_prev;
            if (chip_rst_n & ~chip_prev) strap_q <= strap_in;
        end
    end
endmodule

// File: rtl/loader_trigger.sv
// Loader trigger: holds a pending flag, set by chip-level reset or an
// accepted digital request. Fires a one-cycle start on the edge after
// multi_rst_n rises while the flag is set. Soft reset never sets the flag.
// Assumes: arst_n is the raw chip-level reset.
module loader_trigger (
    input  logic clk,
    input  logic arst_n,
    input  logic chip_rst_n,
    input  logic multi_rst_n,
    input  logic dig_req,
    output logic start
);
    logic pend;
    logic multi_prev;
    logic fire;

    assign fire = multi_rst_n & ~multi_prev & pend;

    // Pending flag: set by chip reset or digital request, cleared on fire.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                    pend <= 1'b1;
        else if (dig_req && chip_rst_n) pend <= 1'b1;
        else if (fire)                  pend <= 1'b0;
    end

    // Edge history of the multi-module reset and the registered pulse.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            multi_prev <= 1'b0;
            start      <= 1'b0;
        end else begin
            multi_prev <= multi_rst_n;
            start      <= fire;
        end
    end
endmodule

// File: rtl/rstgen_hier.sv
// Hierarchical reset controller top.
// Chip tier: por_n and ext_rst_n, asynchronous.
// Multi-module tier: stretched digital and soft requests, under the chip tier.
// Per-module tier: stretched per-module requests, under the multi tier.
// Every tier asserts asynchronously and releases through a synchronizer.
// Assumes: requests are synchronous one-cycle pulses on clk.
module rstgen_hier
    import rstgen_pkg::*;
#(
    parameter int HOLD_CYCLES = HOLD_DEF,
    parameter int NUM_MOD     = NMOD_DEF,
    parameter int STRAP_W     = STRAPW_DEF
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ext_rst_n,
    input  logic               dig_req,
    input  logic               soft_req,
    input  logic [NUM_MOD-1:0] mod_req,
    input  logic [STRAP_W-1:0] strap_in,
    output logic               chip_rst_n,
    output logic               multi_rst_n,
    output logic [NUM_MOD-1:0] mod_rst_n,
    output logic [STRAP_W-1:0] strap_q,
    output logic               strap_stb,
    output logic               loader_start
);
    localparam int NSRC_MULTI = 2;

    logic                  chip_any_n;
    logic [NSRC_MULTI-1:0] multi_act;
    logic [NSRC_MULTI-1:0] multi_reqs;
    logic                  multi_raw_n;
    logic [NUM_MOD-1:0]    mod_act;
    logic [NUM_MOD-1:0]    mod_raw_n;

    // Chip tier: either chip-level source holds the whole tree.
    assign chip_any_n = por_n & ext_rst_n;

    rst_sync #(.STAGES(SYNC_DEF)) u_chip_sync (
        .clk     (clk),
        .arst_n  (chip_any_n),
        .rst_n_o (chip_rst_n)
    );

    // Multi-module tier: one stretcher per register source.
    assign multi_reqs = {soft_req, dig_req};

    for (genvar s = 0; s < NSRC_MULTI; s++) begin : g_multi
        rst_stretch #(.HOLD(HOLD_CYCLES)) u_str (
            .clk    (clk),
            .rst_n  (chip_rst_n),
            .req    (multi_reqs[s]),
            .active (multi_act[s])
        );
    end

    assign multi_raw_n = chip_rst_n & ~(|multi_act);

    rst_sync #(.STAGES(SYNC_DEF)) u_multi_sync (
        .clk     (clk),
        .arst_n  (multi_raw_n),
        .rst_n_o (multi_rst_n)
    );

    // Per-module tier: each module under the multi tier plus its own request.
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
        rst_stretch #(.HOLD(HOLD_CYCLES)) u_str (
            .clk    (clk),
            .rst_n  (multi_rst_n),
            .req    (mod_req[m]),
            .active (mod_act[m])
        );

        assign mod_raw_n[m] = multi_rst_n & ~mod_act[m];

        rst_sync #(.STAGES(SYNC_DEF)) u_sync (
            .clk     (clk),
            .arst_n  (mod_raw_n[m]),
            .rst_n_o (mod_rst_n[m])
        );
    end

    // Straps: latched only on chip-level release.
    strap_capture #(.W(STRAP_W)) u_strap (
        .clk        (clk),
        .arst_n     (chip_any_n),
        .chip_rst_n (chip_rst_n),
        .strap_in   (strap_in),
        .strap_q    (strap_q),
        .strb       (strap_stb)
    );

    // Loader start: after chip-level or digital reset, never soft alone.
    loader_trigger u_ldr (
        .clk         (clk),
        .arst_n      (chip_any_n),
        .chip_rst_n  (chip_rst_n),
        .multi_rst_n (multi_rst_n),
        .dig_req     (dig_req),
        .start       (loader_start)
    );
endmodule

// File: rtl/rstgen_hier_chk.sv
// Checker for rstgen_hier: tier ordering, pulse widths, strap and loader
// timing. Bound to every instance of the top module.
module rstgen_hier_chk #(
    parameter int NUM_MOD = 3,
    parameter int STRAP_W = 8
) (
    input logic               clk,
    input logic               por_n,
    input logic               ext_rst_n,
    input logic               chip_rst_n,
    input logic               multi_rst_n,
    input logic [NUM_MOD-1:0] mod_rst_n,
    input logic [STRAP_W-1:0] strap_in,
    input logic [STRAP_W-1:0] strap_q,
    input logic               strap_stb,
    input logic               loader_start
);
    logic src_ok;
    assign src_ok = por_n & ext_rst_n;

    // R2: chip tier low forces the multi tier low.
    p_chip_over_multi_r2: assert property (@(posedge clk) disable iff (!src_ok)
        !chip_rst_n |-> !multi_rst_n);

    // R2: multi tier low forces every module low.
    p_multi_over_mod_r2: assert property (@(posedge clk) disable iff (!src_ok)
        !multi_rst_n |-> (mod_rst_n == '0));

    // R3: a falling multi reset is held for at least the next cycle.
    p_multi_hold_r3: assert property (@(posedge clk) disable iff (!src_ok)
        $fell(multi_rst_n) |=> !multi_rst_n);

    // R6: the strap strobe lasts one cycle.
    p_strap_pulse_r6: assert property (@(posedge clk) disable iff (!src_ok)
        strap_stb |=> !strap_stb);

    // R6: the captured value is the strap input of the capture edge.
    p_strap_value_r6: assert property (@(posedge clk) disable iff (!src_ok)
        strap_stb |-> (chip_rst_n && strap_q == $past(strap_in)));

    // R7: the loader pulse lasts one cycle.
    p_ld_pulse_r7: assert property (@(posedge clk) disable iff (!src_ok)
        loader_start |=> !loader_start);

    // R7: the loader pulse follows a multi-module release by one edge.
    p_ld_after_multi_r7: assert property (@(posedge clk) disable iff (!src_ok)
        loader_start |-> (multi_rst_n && !$past(multi_rst_n, 2)));
endmodule

bind rstgen_hier rstgen_hier_chk #(.NUM_MOD(NUM_MOD), .STRAP_W(STRAP_W)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .ext_rst_n    (ext_rst_n),
    .chip_rst_n   (chip_rst_n),
    .multi_rst_n  (multi_rst_n),
    .mod_rst_n    (mod_rst_n),
    .strap_in     (strap_in),
    .strap_q      (strap_q),
    .strap_stb    (strap_stb),
    .loader_start (loader_start)
);

// File: tb/tb_rstgen_hier.sv
`timescale 1ns/100ps
// Directed bench for rstgen_hier: one task per scenario, each checks itself.
module tb_rstgen_hier;
    localparam int NM = 3;
    localparam int SW = 8;
    localparam int WIN = 30;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          ext_rst_n = 1'b1;
    logic          dig_req = 1'b0;
    logic          soft_req = 1'b0;
    logic [NM-1:0] mod_req = '0;
    logic [SW-1:0] strap_in = 8'hA5;
    logic          chip_rst_n;
    logic          multi_rst_n;
    logic [NM-1:0] mod_rst_n;
    logic [SW-1:0] strap_q;
    logic          strap_stb;
    logic          loader_start;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Results of one observation window.
    int chip_first, multi_first, stb_first, stb_cnt, ld_first, ld_cnt;
    int mod_first [NM];
    int mod_low   [NM];
    int multi_low;

    rstgen_hier dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .dig_req(dig_req),
        .soft_req(soft_req), .mod_req(mod_req), .strap_in(strap_in),
        .chip_rst_n(chip_rst_n), .multi_rst_n(multi_rst_n),
        .mod_rst_n(mod_rst_n), .strap_q(strap_q), .strap_stb(strap_stb),
        .loader_start(loader_start)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<=50000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Sample on falling edges; index 'start' is the first sample.
    task automatic watch(input int start);
        chip_first = -1; multi_first = -1; stb_first = -1; ld_first = -1;
        stb_cnt = 0; ld_cnt = 0; multi_low = 0;
        for (int b = 0; b < NM; b++) begin mod_first[b] = -1; mod_low[b] = 0; end
        for (int i = start; i < start + WIN; i++) begin
            @(negedge clk);
            if (chip_rst_n && chip_first < 0)   chip_first = i;
            if (multi_rst_n && multi_first < 0) multi_first = i;
            if (!multi_rst_n) multi_low = 1;
            if (strap_stb) begin stb_cnt++; if (stb_first < 0) stb_first = i; end
            if (loader_start) begin ld_cnt++; if (ld_first < 0) ld_first = i; end
            for (int b = 0; b < NM; b++) begin
                if (mod_rst_n[b] && mod_first[b] < 0) mod_first[b] = i;
                if (!mod_rst_n[b]) mod_low[b] = 1;
            end
        end
    endtask

    // One-cycle request pulse; returns just after the sampling edge.
    task automatic pulse(input int kind, input int bitn);
        @(negedge clk);
        case (kind)
            0: dig_req = 1'b1;
            1: soft_req = 1'b1;
            default: mod_req[bitn] = 1'b1;
        endcase
        @(posedge clk);
        #1;
        dig_req = 1'b0; soft_req = 1'b0; mod_req = '0;
    endtask

    task automatic t_por();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset chip", int'(chip_rst_n), 0);
        chk("R1 reset multi", int'(multi_rst_n), 0);
        chk("R1 reset mod", int'(mod_rst_n), 0);
        chk("R1 reset strap", int'(strap_q), 0);
        @(negedge clk);
        por_n = 1'b1;
        watch(1);
        chk("R1 chip release", chip_first, 2);
        chk("R2 multi release", multi_first, 4);
        for (int b = 0; b < NM; b++) chk("R2 mod release", mod_first[b], 6);
        chk("R6 strobe edge", stb_first, 3);
        chk("R6 strobe count", stb_cnt, 1);
        chk("R6 strap value", int'(strap_q), 'hA5);
        chk("R7 loader edge", ld_first, 5);
        chk("R7 loader count", ld_cnt, 1);
    endtask

    task automatic t_ext();
        @(negedge clk);
        ext_rst_n = 1'b0;
        #1;
        chk("R1 ext async chip", int'(chip_rst_n), 0);
        chk("R1 ext async mod", int'(mod_rst_n), 0);
        strap_in = 8'h3C;
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b1;
        watch(1);
        chip_rst_n_chk: chk("R1 ext release", chip_first, 2);
        chk("R6 ext strap value", int'(strap_q), 'h3C);
        chk("R6 ext strobe count", stb_cnt, 1);
        chk("R7 ext loader edge", ld_first, 5);
    endtask

    task automatic t_digital();
        strap_in = 8'h81;
        pulse(0, 0);
        watch(0);
        chk("R3 digital multi release", multi_first, 18);
        chk("R3 digital mod release", mod_first[0], 20);
        chk("R7 digital loader edge", ld_first, 19);
        chk("R7 digital loader count", ld_cnt, 1);
        chk("R6 no strobe on digital", stb_cnt, 0);
        chk("R6 strap kept on digital", int'(strap_q), 'h3C);
    endtask

    task automatic t_soft();
        pulse(1, 0);
        watch(0);
        chk("R3 soft multi release", multi_first, 18);
        chk("R3 soft mod release", mod_first[2], 20);
        chk("R8 soft loader count", ld_cnt, 0);
        chk("R8 soft strobe count", stb_cnt, 0);
        chk("R8 soft strap kept", int'(strap_q), 'h3C);
    endtask

    task automatic t_mod(input int bitn);
        pulse(2, bitn);
        watch(0);
        chk("R4 module release", mod_first[bitn], 18);
        for (int b = 0; b < NM; b++)
            if (b != bitn) chk("R4 other module untouched", mod_low[b], 0);
        chk("R4 multi untouched", multi_low, 0);
        chk("R4 no loader", ld_cnt, 0);
    endtask

    task automatic t_restart();
        pulse(0, 0);
        repeat (3) @(negedge clk);
        pulse(0, 0);
        watch(0);
        chk("R5 restart multi release", multi_first, 18);
        chk("R5 restart loader count", ld_cnt, 1);
        pulse(2, 2);
        repeat (9) @(negedge clk);
        pulse(2, 2);
        watch(0);
        chk("R5 restart module release", mod_first[2], 18);
    endtask

    initial begin
        t_por();
        t_ext();
        t_digital();
        t_soft();
        t_mod(0);
        t_mod(1);
        t_mod(2);
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule